// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block keeps the load-reserve/store-conditional reservations for several hardware thread contexts that share one memory. Each context may take a reservation on a physical address with a locked load. A later store-conditional from that context is allowed to write only if the reservation is still intact. Every write that reaches memory removes the reservations that cover the same 16-byte block, in all contexts. Address translation, caches and the memory array are outside the block. It sees one request per cycle and answers one cycle later with a result bit and a write enable.

Each context also has a counter of store-conditional failures in a row. Every time that counter reaches a multiple of a set period, the block sends a one-cycle warning that names the context, so that livelock between contexts can be seen. The counter stops at its maximum value, and after that no more warnings come. A store-conditional flagged as uncacheable skips the reservation check. It always writes, returns no result and clears the issuer's counter.

Top module: `lrsc_monitor`

## Requirements
- R1: A locked load (op code 0) from context c stores its address as c's reservation block and sets c's reservation flag. It produces neither a write nor a result.
- R2: A store-conditional (op code 1) writes (`mem_we_o` high) only when the issuer's flag is set and the stored block equals the store address with address bits [3:0] ignored.
- R3: A store-conditional raises `sc_rsp_vld_o`, and `sc_rsp_ok_o` equals the issuer's reservation flag as it was before the attempt, even when the block comparison fails. A failed attempt clears the issuer's flag.
- R4: A failed store-conditional gives no write and leaves the reservations of other contexts untouched.
- R5: A successful store-conditional, an ordinary store (op code 2) or an uncacheable store-conditional clears the flag of every context whose block matches the store address (bits [3:0] ignored), the issuer included. Contexts holding other blocks keep their flags. Ordinary stores always write.
- R6: An uncacheable store-conditional (op code 3) always writes, leaves `sc_rsp_vld_o` low and resets the issuer's failure counter.
- R7: Each context counts store-conditional failures in a row. A successful store-conditional resets its count to zero.
- R8: When a context's failure count reaches a non-zero multiple of WARN_PERIOD, `warn_o` is high for exactly one cycle and `warn_ctx_o` holds that context's index.
- R9: The failure count stops at 2^CNT_W-1 and does not wrap. Failures beyond that raise no warning.
- R10: All outputs appear in the cycle after the request. A cycle with no request gives no write and no result.
- R11: Reset clears all reservation flags and all failure counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Request valid |
| req_ctx_i | input | CTX_W | Issuing context index |
| req_op_i | input | 2 | 0 locked load, 1 store-conditional, 2 store, 3 uncacheable store-conditional |
| req_addr_i | input | ADDR_W | Physical address |
| sc_rsp_vld_o | output | 1 | Store-conditional result valid |
| sc_rsp_ok_o | output | 1 | Store-conditional result bit |
| mem_we_o | output | 1 | Memory write permitted |
| warn_o | output | 1 | Failure-streak warning pulse |
| warn_ctx_o | output | CTX_W | Context named by the warning |

## Verification
The hardest states to reach are at the two ends of the failure counter: a warning that lands exactly on a multiple of the period, and the stop at saturation after which warnings must cease. The bench is built with a small period and a narrow counter, so the stimulus reaches both ends after a few failed store-conditionals. It then clears the streak with a success, with an uncacheable store-conditional or with reset, and checks that the next warning comes only after a full new period. Cross-context invalidation is reached by holding reservations in several contexts on the same block and on different blocks before one store.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LL    = 2'd0,
    OP_SC    = 2'd1,
    OP_ST    = 2'd2,
    OP_SC_UC = 2'd3
  } lrsc_op_e;
endpackage

// File: rtl/lrsc_resv_slot.sv
module lrsc_resv_slot #(
  parameter int BLK_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             set_i,
  input  logic             own_fail_i,
  input  logic             inval_i,
  output logic             vld_o,
  output logic             hit_o
);
  logic [BLK_W-1:0] blk_q;
  logic             vld_q;

  assign hit_o = (blk_q == blk_i);
  assign vld_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      blk_q <= '0;
    end else begin
      // clearing wins over setting
      if ((inval_i && hit_o) || own_fail_i) vld_q <= 1'b0;
      else if (set_i) vld_q <= 1'b1;
      if (set_i) blk_q <= blk_i;
    end
  end
endmodule

// File: rtl/lrsc_fail_ctr.sv
module lrsc_fail_ctr #(
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic clr_i,
  output logic warn_o
);
  localparam int PH_W = (WARN_PERIOD > 2) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(WARN_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic             step;

  assign step   = fail_i && (cnt_q != CNT_MAX);
  assign warn_o = step && (ph_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      ph_q  <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_vld_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              sc_rsp_vld_o,
  output logic              sc_rsp_ok_o,
  output logic              mem_we_o,
  output logic              warn_o,
  output logic [CTX_W-1:0]  warn_ctx_o
);
  localparam int BLK_W = ADDR_W - GRAN_BITS;

  lrsc_op_e         op;
  logic [BLK_W-1:0] blk;
  logic             is_ll, is_sc, is_st, is_uc;
  logic [NUM_CTX-1:0] rsv_vld, rsv_hit, warn_hit;
  logic             own_vld, own_hit, sc_ok, inval;

  assign op    = lrsc_op_e'(req_op_i);
  assign blk   = req_addr_i[ADDR_W-1:GRAN_BITS];
  assign is_ll = req_vld_i && (op == OP_LL);
  assign is_sc = req_vld_i && (op == OP_SC);
  assign is_st = req_vld_i && (op == OP_ST);
  assign is_uc = req_vld_i && (op == OP_SC_UC);

  assign own_vld = rsv_vld[req_ctx_i];
  assign own_hit = rsv_hit[req_ctx_i];
  assign sc_ok   = is_sc && own_vld && own_hit;
  assign inval   = is_st || is_uc || sc_ok;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic sel;
    assign sel = (req_ctx_i == CTX_W'(g));

    lrsc_resv_slot #(.BLK_W(BLK_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .blk_i      (blk),
      .set_i      (is_ll && sel),
      .own_fail_i (is_sc && sel && !sc_ok),
      .inval_i    (inval),
      .vld_o      (rsv_vld[g]),
      .hit_o      (rsv_hit[g])
    );

    lrsc_fail_ctr #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fail_i (is_sc && sel && !sc_ok),
      .clr_i  (sel && (sc_ok || is_uc)),
      .warn_o (warn_hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_rsp_vld_o <= 1'b0;
      sc_rsp_ok_o  <= 1'b0;
      mem_we_o     <= 1'b0;
      warn_o       <= 1'b0;
      warn_ctx_o   <= '0;
    end else begin
      sc_rsp_vld_o <= is_sc;
      sc_rsp_ok_o  <= is_sc && own_vld;
      mem_we_o     <= inval;
      warn_o       <= |warn_hit;
      if (|warn_hit) warn_ctx_o <= req_ctx_i;
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 32,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_vld_i,
  input logic [CTX_W-1:0]  req_ctx_i,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              sc_rsp_vld_o,
  input logic              sc_rsp_ok_o,
  input logic              mem_we_o,
  input logic              warn_o,
  input logic [CTX_W-1:0]  warn_ctx_o
);
  AST_LL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && req_op_i == 2'd0) |=> (!mem_we_o && !sc_rsp_vld_o)); // R1
  AST_FAIL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_rsp_vld_o && !sc_rsp_ok_o) |-> !mem_we_o); // R4
  AST_STORE_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && req_op_i == 2'd2) |=> (mem_we_o && !sc_rsp_vld_o)); // R5
  AST_UC_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && req_op_i == 2'd3) |=> (mem_we_o && !sc_rsp_vld_o)); // R6
  AST_WARN_AFTER_SC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> $past(req_vld_i && req_op_i == 2'd1)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> (!mem_we_o && !sc_rsp_vld_o && !warn_o)); // R10
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_vld_i    (req_vld_i),
  .req_ctx_i    (req_ctx_i),
  .req_op_i     (req_op_i),
  .req_addr_i   (req_addr_i),
  .sc_rsp_vld_o (sc_rsp_vld_o),
  .sc_rsp_ok_o  (sc_rsp_ok_o),
  .mem_we_o     (mem_we_o),
  .warn_o       (warn_o),
  .warn_ctx_o   (warn_ctx_o)
);

// File: tb/lrsc_monitor_test.sv
`timescale 1ns/1ps
module lrsc_monitor_test;
  localparam int NUM_CTX = 4;
  localparam int ADDR_W  = 32;
  localparam int CTX_W   = 2;
  localparam int PERIOD  = 3;
  localparam int CW      = 3;  // saturates at 7

  localparam logic [1:0] LL = 2'd0, SC = 2'd1, ST = 2'd2, UC = 2'd3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vld = 1'b0;
  logic [CTX_W-1:0]  ctx = '0;
  logic [1:0]        op = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rsp_vld, rsp_ok, we, warn;
  logic [CTX_W-1:0]  warn_ctx;

  int n_chk = 0, n_fail = 0;
  logic s_vld, s_ok, s_we, s_warn;
  logic [CTX_W-1:0] s_wctx;

  always #5 clk = ~clk;

  lrsc_monitor #(
    .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN_BITS(4),
    .CNT_W(CW), .WARN_PERIOD(PERIOD)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_vld_i(vld), .req_ctx_i(ctx),
    .req_op_i(op), .req_addr_i(addr), .sc_rsp_vld_o(rsp_vld),
    .sc_rsp_ok_o(rsp_ok), .mem_we_o(we), .warn_o(warn), .warn_ctx_o(warn_ctx)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int c, input logic [1:0] o, input logic [31:0] a);
    @(negedge clk);
    vld = 1'b1; ctx = CTX_W'(c); op = o; addr = a;
    @(posedge clk); #1;
    s_vld = rsp_vld; s_ok = rsp_ok; s_we = we; s_warn = warn; s_wctx = warn_ctx;
    vld = 1'b0;
  endtask

  // check {rsp_vld, rsp_ok, we}
  task automatic expect_out(input string req, input logic v, input logic k, input logic w);
    chk(req, {5'd0, s_vld, s_ok, s_we}, {5'd0, v, k, w});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R11 outputs in reset", {4'd0, rsp_vld, we, warn, 1'b0}, 8'd0);
    do_reset();
    for (int c = 0; c < NUM_CTX; c++) begin
      issue(c, SC, 32'h100);
      expect_out("R11 no reservation after reset", 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_basic();
    issue(0, LL, 32'h1000);
    expect_out("R1 locked load silent", 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R10 idle quiet", {5'd0, rsp_vld, rsp_ok, we}, 8'd0);
    issue(0, SC, 32'h100F);
    expect_out("R2 SC same block low bits ignored", 1'b1, 1'b1, 1'b1);
    issue(0, SC, 32'h1000);
    expect_out("R5 own flag cleared by success", 1'b1, 1'b0, 1'b0);
    issue(1, LL, 32'h2000);
    issue(1, SC, 32'h2010);
    expect_out("R3 result is flag despite mismatch", 1'b1, 1'b1, 1'b0);
    issue(1, SC, 32'h2000);
    expect_out("R3 flag cleared by failure", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_others();
    issue(0, LL, 32'h3000);
    issue(1, LL, 32'h3004);
    issue(0, SC, 32'h4000);
    expect_out("R4 failed SC no write", 1'b1, 1'b1, 1'b0);
    issue(1, SC, 32'h3008);
    expect_out("R4 other reservation kept", 1'b1, 1'b1, 1'b1);
    issue(2, LL, 32'h5000);
    issue(3, LL, 32'h5008);
    issue(2, SC, 32'h5000);
    expect_out("R2 SC success", 1'b1, 1'b1, 1'b1);
    issue(3, SC, 32'h5000);
    expect_out("R5 success invalidates other ctx", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_store();
    issue(0, LL, 32'h6000);
    issue(1, LL, 32'h6008);
    issue(2, LL, 32'h7000);
    issue(3, ST, 32'h6004);
    expect_out("R5 store writes", 1'b0, 1'b0, 1'b1);
    issue(0, SC, 32'h6000);
    expect_out("R5 store cleared ctx0", 1'b1, 1'b0, 1'b0);
    issue(1, SC, 32'h6008);
    expect_out("R5 store cleared ctx1", 1'b1, 1'b0, 1'b0);
    issue(2, SC, 32'h7000);
    expect_out("R5 other block kept", 1'b1, 1'b1, 1'b1);
    issue(0, LL, 32'h8000);
    issue(0, ST, 32'h8000);
    issue(0, SC, 32'h8000);
    expect_out("R5 own store clears issuer", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_uncached();
    issue(0, LL, 32'h9000);
    issue(1, UC, 32'h9000);
    expect_out("R6 uncacheable writes no result", 1'b0, 1'b0, 1'b1);
    issue(0, SC, 32'h9000);
    expect_out("R5 uncacheable invalidates", 1'b1, 1'b0, 1'b0);
    issue(2, UC, 32'hA000);
    expect_out("R6 write without reservation", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic fail_n(input int c, input int n, input string req, input int warn_at);
    for (int i = 1; i <= n; i++) begin
      issue(c, SC, 32'hF000);
      chk(req, {7'd0, s_warn}, {7'd0, (i == warn_at)});
      if (i == warn_at) chk({req, " ctx"}, {6'd0, s_wctx}, 8'(c));
    end
  endtask

  task automatic t_counter();
    do_reset();
    fail_n(1, 3, "R8 first warning", 3);
    fail_n(1, 3, "R8 second warning", 3);
    fail_n(1, 4, "R9 saturated no warning", 0);
    issue(1, UC, 32'hF000);
    fail_n(1, 3, "R6 uncacheable resets counter", 3);
    fail_n(2, 2, "R7 streak start", 0);
    issue(2, LL, 32'hE000);
    issue(2, SC, 32'hE000);
    chk("R7 success no warn", {7'd0, s_warn}, 8'd0);
    fail_n(2, 3, "R7 success resets counter", 3);
    fail_n(3, 2, "R11 before reset", 0);
    do_reset();
    fail_n(3, 3, "R11 counter cleared", 3);
    @(posedge clk); #1;
    chk("R8 warning one cycle", {7'd0, warn}, 8'd0);
  endtask

  initial begin
    #1;
    t_reset();
    t_basic();
    t_others();
    t_store();
    t_uncached();
    t_counter();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule